// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Port

This block is one access port of a synchronous memory whose 18-bit words are split into two 9-bit byte lanes. On every rising clock edge it samples a pair of chip selects of opposite polarity, two active-low lane enables and a read/write strobe. From these it performs a lane-masked write into a register-array memory, or a lane-masked read into a registered output stage.

The outputs model a tri-state bus as a data word plus one output-enable bit per lane. The per-lane enable flags are registered at the clock edge. An asynchronous output-disable input masks them combinationally, so it takes effect at once and does not wait for a clock. A lane that is not driven reads as zero on the data port. The memory contents start at zero in simulation.

Top module: `byte_lane_sram_port`

## Requirements
- R1: A word is 18 bits. Lane 1 (upper) is bits 17:9 and lane 0 (lower) is bits 8:0. Bit g of `lane_en_n` and bit g of `lane_oe` refer to lane g.
- R2: If `sel_hi_n` is 1 or `sel_lo` is 0 at a clock edge, the port is deselected. Nothing is written, and after that edge `lane_oe` is 2'b00.
- R3: If the port is selected and `lane_en_n` is 2'b11 at an edge, nothing is written, and after that edge `lane_oe` is 2'b00.
- R4: If the port is selected and `wr_n` is 0 at an edge, each lane whose `lane_en_n` bit is 0 stores its slice of `wdata` at `addr`. Each other lane keeps its content.
- R5: If the port is selected and `wr_n` is 1 at an edge, after that edge `lane_oe` equals `~lane_en_n` (while `out_dis` is 0). Each enabled lane shows the content stored at `addr`.
- R6: While `out_dis` is 1, `lane_oe` is 2'b00 and `rdata` is zero, without waiting for a clock edge. When `out_dis` returns to 0, the registered flags reappear at once.
- R7: After an edge that samples a write, `lane_oe` is 2'b00.
- R8: Every lane whose `lane_oe` bit is 0 reads as zero on `rdata`.
- R9: If `rst_n` is 0 at an edge (a synchronous reset), `lane_oe` is 2'b00 after that edge.
- R10: A word that has never been written reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the output flags |
| sel_hi_n | input | 1 | Chip select, active low |
| sel_lo | input | 1 | Chip select, active high |
| lane_en_n | input | 2 | Per-lane enables, active low, bit 1 = upper lane |
| wr_n | input | 1 | 1 = read, 0 = write |
| out_dis | input | 1 | Asynchronous output disable, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data, zero on lanes not driven |
| lane_oe | output | 2 | Per-lane output enable |

## Verification
The bench targets single-lane writes followed by reads of both lanes:
- A shared write strobe would corrupt the untouched lane.
- A swapped lane mapping would put the wrong 9 bits on the wrong half.

It deselects the port through each chip select in turn, and also with both lanes idle. A later read of the same word exposes any write that leaked through.

It toggles `out_dis` between clock edges to catch gating that was wrongly made synchronous. It also holds `out_dis` across an edge to catch a design that wrongly cleared the registered flags. A reset applied during a read command must still leave both lanes undriven.

// File: rtl/blsp_pkg.sv
`timescale 1ns/1ps
// Shared geometry and command types for the byte-lane SRAM port.
// Assumes exactly two lanes: lane 1 is the upper half of the word.
package blsp_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    // Per-lane strobes produced by the decoder for one clock edge.
    typedef struct packed {
        lane_mask_t wr;
        lane_mask_t rd;
    } lane_cmd_t;
endpackage

// File: rtl/blsp_decode.sv
`timescale 1ns/1ps
// Turns chip selects, lane enables and the read/write strobe into
// per-lane write and read strobes. Purely combinational; the strobes
// are used at the next rising clock edge.
module blsp_decode
    import blsp_pkg::*;
(
    input  logic       sel_hi_n,
    input  logic       sel_lo,
    input  lane_mask_t lane_en_n,
    input  logic       wr_n,
    output lane_cmd_t  cmd
);
    logic       port_on;
    lane_mask_t lanes;

    // Select the port and pick the lanes taking part in this access.
    always_comb begin
        port_on = !sel_hi_n && sel_lo;
        lanes   = port_on ? ~lane_en_n : '0;
        cmd.wr  = wr_n ? '0 : lanes;
        cmd.rd  = wr_n ? lanes : '0;
    end
endmodule

// File: rtl/blsp_store.sv
`timescale 1ns/1ps
// Register-array storage: one bank per lane so each lane writes alone.
// Reads are asynchronous from the current address; the output stage
// registers them. Banks start at zero in simulation.
module blsp_store
    import blsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  lane_mask_t        wr_lanes,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        // Start every word at zero for simulation.
        initial begin
            for (int i = 0; i < DEPTH; i++) bank[i] = '0;
        end

        // Store this lane's slice when its write strobe is set.
        always_ff @(posedge clk) begin
            if (wr_lanes[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = bank[addr];
    end
endmodule

// File: rtl/blsp_out.sv
`timescale 1ns/1ps
// Output stage: registers read data and per-lane valid flags on the
// clock edge, then gates them with the asynchronous output disable.
// Lanes not driven present zero on the data port.
module blsp_out
    import blsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lane_mask_t rd_lanes,
    input  word_t      rd_word,
    input  logic       out_dis,
    output word_t      rdata,
    output lane_mask_t lane_oe
);
    lane_mask_t valid_q;
    word_t      data_q;

    // Capture which lanes drive after this edge; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= rd_lanes;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold the lane's read data from the last read of that lane.
        always_ff @(posedge clk) begin
            if (rd_lanes[g]) data_q[g*LANE_W +: LANE_W] <= rd_word[g*LANE_W +: LANE_W];
        end

        // Mask the lane combinationally with the output disable.
        always_comb begin
            lane_oe[g] = valid_q[g] && !out_dis;
            rdata[g*LANE_W +: LANE_W] = lane_oe[g] ? data_q[g*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/byte_lane_sram_port.sv
`timescale 1ns/1ps
// One synchronous port of an 18-bit memory with two 9-bit lanes.
// Assumes a single clock domain; out_dis is the only input used
// without a clock and it affects only the outputs.
module byte_lane_sram_port
    import blsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hi_n,
    input  logic              sel_lo,
    input  logic [1:0]        lane_en_n,
    input  logic              wr_n,
    input  logic              out_dis,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic [1:0]        lane_oe
);
    lane_cmd_t cmd;
    word_t     rd_word;

    blsp_decode i_decode (
        .sel_hi_n  (sel_hi_n),
        .sel_lo    (sel_lo),
        .lane_en_n (lane_en_n),
        .wr_n      (wr_n),
        .cmd       (cmd)
    );

    blsp_store #(.ADDR_W(ADDR_W)) i_store (
        .clk      (clk),
        .wr_lanes (cmd.wr),
        .addr     (addr),
        .wdata    (wdata),
        .rd_word  (rd_word)
    );

    blsp_out i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lanes (cmd.rd),
        .rd_word  (rd_word),
        .out_dis  (out_dis),
        .rdata    (rdata),
        .lane_oe  (lane_oe)
    );
endmodule

// File: rtl/blsp_port_chk.sv
`timescale 1ns/1ps
// Protocol checks on the port, attached to every instance by bind.
module blsp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_hi_n,
    input logic       sel_lo,
    input logic       wr_n,
    input logic       out_dis,
    input logic [1:0] lane_en_n,
    input logic [1:0] lane_oe,
    input logic [17:0] rdata
);
    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hi_n || !sel_lo) |=> (lane_oe == 2'b00));

    assert_idle_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_hi_n && sel_lo && lane_en_n == 2'b11) |=> (lane_oe == 2'b00));

    assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_hi_n && sel_lo && wr_n) |=> (lane_oe == (~$past(lane_en_n) & {2{!out_dis}})));

    assert_dis_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (lane_oe == 2'b00 && rdata == 18'h0));

    assert_write_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (lane_oe == 2'b00));

    assert_undriven_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[0] |-> (rdata[8:0] == 9'h0));

    assert_undriven_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe[1] |-> (rdata[17:9] == 9'h0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (lane_oe == 2'b00));
endmodule

bind byte_lane_sram_port blsp_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_hi_n  (sel_hi_n),
    .sel_lo    (sel_lo),
    .wr_n      (wr_n),
    .out_dis   (out_dis),
    .lane_en_n (lane_en_n),
    .lane_oe   (lane_oe),
    .rdata     (rdata)
);

// File: tb/test_byte_lane_sram_port.sv
`timescale 1ns/1ps
module test_byte_lane_sram_port;
    typedef struct packed {
        logic        hn;
        logic        lo;
        logic [1:0]  len;
        logic        wn;
        logic [7:0]  a;
        logic [17:0] d;
        logic [1:0]  eoe;
        logic [17:0] erd;
        logic [3:0]  req;
    } vec_t;

    // One row per clock edge; expectations sampled just after that edge.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'b00, 1'b0, 8'd5, 18'h2AAAA, 2'b00, 18'h00000, 4'd4},  // R4 R7 write both
        '{1'b0, 1'b1, 2'b00, 1'b1, 8'd5, 18'h00000, 2'b11, 18'h2AAAA, 4'd5},  // R5 read both
        '{1'b0, 1'b1, 2'b10, 1'b0, 8'd5, 18'h3FFFF, 2'b00, 18'h00000, 4'd4},  // R4 write lower only
        '{1'b0, 1'b1, 2'b00, 1'b1, 8'd5, 18'h00000, 2'b11, 18'h2ABFF, 4'd4},  // R4 upper kept
        '{1'b0, 1'b1, 2'b01, 1'b0, 8'd5, 18'h1E000, 2'b00, 18'h00000, 4'd4},  // R4 write upper only
        '{1'b0, 1'b1, 2'b10, 1'b1, 8'd5, 18'h00000, 2'b01, 18'h001FF, 4'd8},  // R8 R5 lower only
        '{1'b0, 1'b1, 2'b01, 1'b1, 8'd5, 18'h00000, 2'b10, 18'h1E000, 4'd8},  // R8 R5 upper only
        '{1'b1, 1'b1, 2'b00, 1'b0, 8'd5, 18'h00000, 2'b00, 18'h00000, 4'd2},  // R2 sel_hi_n high
        '{1'b0, 1'b0, 2'b00, 1'b0, 8'd5, 18'h00000, 2'b00, 18'h00000, 4'd2},  // R2 sel_lo low
        '{1'b0, 1'b1, 2'b11, 1'b0, 8'd5, 18'h00000, 2'b00, 18'h00000, 4'd3},  // R3 no lanes
        '{1'b0, 1'b1, 2'b00, 1'b1, 8'd5, 18'h00000, 2'b11, 18'h1E1FF, 4'd3},  // R2 R3 nothing leaked
        '{1'b1, 1'b1, 2'b00, 1'b1, 8'd5, 18'h00000, 2'b00, 18'h00000, 4'd2},  // R2 deselected read
        '{1'b0, 1'b1, 2'b00, 1'b1, 8'd9, 18'h00000, 2'b11, 18'h00000, 4'd10}, // R10 unwritten word
        '{1'b0, 1'b1, 2'b00, 1'b0, 8'd9, 18'h12345, 2'b00, 18'h00000, 4'd7},  // R7 write hides lanes
        '{1'b0, 1'b1, 2'b00, 1'b1, 8'd9, 18'h00000, 2'b11, 18'h12345, 4'd1}   // R1 full word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_hi_n = 1'b1;
    logic        sel_lo = 1'b0;
    logic [1:0]  lane_en_n = 2'b11;
    logic        wr_n = 1'b1;
    logic        out_dis = 1'b0;
    logic [7:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic [1:0]  lane_oe;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_lane_sram_port #(.ADDR_W(8)) i_byte_lane_sram_port (
        .clk(clk), .rst_n(rst_n), .sel_hi_n(sel_hi_n), .sel_lo(sel_lo),
        .lane_en_n(lane_en_n), .wr_n(wr_n), .out_dis(out_dis),
        .addr(addr), .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one command, let one edge pass, return 1 ns after it.
    task automatic step(input logic hn, input logic lo, input logic [1:0] len,
                        input logic wn, input logic [7:0] a, input logic [17:0] d);
        sel_hi_n = hn; sel_lo = lo; lane_en_n = len; wr_n = wn; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", "lane_oe after reset", {16'h0, lane_oe}, 18'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].hn, VECS[i].lo, VECS[i].len, VECS[i].wn, VECS[i].a, VECS[i].d);
            check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d lane_oe", i),
                  {16'h0, lane_oe}, {16'h0, VECS[i].eoe});
            check($sformatf("R%0d", VECS[i].req), $sformatf("row %0d rdata", i),
                  rdata, VECS[i].erd);
        end

        // R6: disable between edges acts at once, and releases at once.
        out_dis = 1'b1; #1;
        check("R6", "lane_oe disabled", {16'h0, lane_oe}, 18'h0);
        check("R6", "rdata disabled", rdata, 18'h0);
        out_dis = 1'b0; #1;
        check("R6", "lane_oe restored", {16'h0, lane_oe}, 18'h3);
        check("R6", "rdata restored", rdata, 18'h12345);

        // R1: the lower lane is bits 8:0, the upper lane bits 17:9.
        step(1'b0, 1'b1, 2'b10, 1'b1, 8'd9, 18'h0);
        check("R1", "lower slice", rdata, 18'h00145);
        step(1'b0, 1'b1, 2'b01, 1'b1, 8'd9, 18'h0);
        check("R1", "upper slice", rdata, 18'h12200);

        // R6: the disable masks only; the flags register underneath it.
        out_dis = 1'b1;
        step(1'b0, 1'b1, 2'b00, 1'b1, 8'd9, 18'h0);
        check("R6", "lane_oe held off across edge", {16'h0, lane_oe}, 18'h0);
        out_dis = 1'b0; #1;
        check("R6", "flags reappear", {16'h0, lane_oe}, 18'h3);

        // R9: reset during a read command leaves both lanes undriven.
        rst_n = 1'b0;
        step(1'b0, 1'b1, 2'b00, 1'b1, 8'd9, 18'h0);
        check("R9", "lane_oe in reset", {16'h0, lane_oe}, 18'h0);
        check("R9", "rdata in reset", rdata, 18'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 2'b00, 1'b1, 8'd9, 18'h0);
        check("R5", "read after reset", rdata, 18'h12345);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule